// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block carries out the operand side of a two-operand add. It receives a mode code, two register indices and a 16-bit literal field. From these it resolves the second source operand and returns it together with its sum with the first register operand. Depending on the mode, the operand comes straight from the register file, from the literal, or from a word-addressed data memory after one or two dependent reads. The memory reads use a request/ready handshake with a separate read-response strobe.

A start pulse is accepted only while the unit is idle. The unit first reads both register indices through its register-file read ports. It then works out the effective address and runs the memory reads the mode needs. When the result is ready it raises a one-cycle done strobe, with the operand and the sum held on the outputs. The literal field is sign-extended to the data width wherever it is used, whether as a value or as an address. An undefined mode code completes with an error flag and makes no memory access.

Top module: `opnd_fetch_unit`

## Requirements
- R1: After reset, and until the first accepted start, `done`, `err`, `busy` and `mem_req` are all low.
- R2: Mode 0 (register) returns as operand the register-file word at index `rb_idx`, and as result the word at `ra_idx` plus that operand (modulo 2^32). It makes no memory access.
- R3: Mode 1 (immediate) returns as operand the 16-bit `lit` sign-extended to 32 bits, adds it to the word at `ra_idx`, and makes no memory access.
- R4: Mode 2 (displacement) makes exactly one memory read, at the word at `rb_idx` plus sign-extended `lit`. The read data is the operand.
- R5: Mode 3 (register indirect) makes exactly one memory read, at the word at `rb_idx`. The read data is the operand.
- R6: Mode 4 (direct) makes exactly one memory read, at sign-extended `lit`. The read data is the operand.
- R7: Mode 5 (memory indirect) makes exactly two reads. The first is at the word at `rb_idx`. The second is at the data returned by the first. The second read's data is the operand.
- R8: Once raised, `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_ready` high. It is low in the cycle after that handshake. Exactly one `mem_rvalid` pulse is taken per handshake, and a `mem_rvalid` pulse while no read is outstanding is ignored.
- R9: `done` is high for exactly one cycle per accepted start, with `operand` and `result` valid in that cycle. `busy` is high from the cycle after an accepted start through the done cycle, and low in the cycle after done.
- R10: A `start` pulse while `busy` is high is ignored: it yields no second done, and the running operation's result is unchanged.
- R11: Mode codes 6 and 7 complete with `err` high in the done cycle, make no memory access, and return zero for both operand and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| mode | input | 3 | Addressing-mode code |
| ra_idx | input | 5 | Index of the first source register |
| rb_idx | input | 5 | Index of the base / second source register |
| lit | input | 16 | Signed displacement, immediate or absolute address |
| busy | output | 1 | Operation in progress |
| rf_a_idx | output | 5 | Register-file read index, port A |
| rf_a_data | input | 32 | Register-file read data, port A (same cycle) |
| rf_b_idx | output | 5 | Register-file read index, port B |
| rf_b_data | input | 32 | Register-file read data, port B (same cycle) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory word address |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Undefined mode, valid with done |
| operand | output | 32 | Resolved second operand |
| result | output | 32 | Sum of first register and operand |

## Verification
The hardest case is memory indirect under a slow memory. Here the second request is built from data that arrives only after the first handshake. That data must be taken from exactly one response, while the request is held over several stalled cycles. The bench memory model is driven by a vector table that sets a separate accept latency and response latency for each operation. It can also inject a stray read response while the unit is idle. A memory-indirect vector with both latencies at their maximum then exercises both the held request and the dependent second address. A directed test fires a second start in the middle of an operation.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

    localparam int DATA_W = 32;
    localparam int LIT_W  = 16;
    localparam int RIDX_W = 5;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_REG    = 3'd0,
        AM_IMM    = 3'd1,
        AM_DISP   = 3'd2,
        AM_RIND   = 3'd3,
        AM_DIRECT = 3'd4,
        AM_MIND   = 3'd5
    } amode_e;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_ONE  = 2'd1,
        RD_TWO  = 2'd2
    } nreads_e;

    typedef struct packed {
        nreads_e           nreads;
        logic              bad;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] value;
    } fetch_plan_t;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_FETCH,
        TS_MEM1,
        TS_MEM2,
        TS_DONE
    } top_state_e;

    typedef enum logic [1:0] {
        MP_IDLE,
        MP_REQ,
        MP_WAIT
    } port_state_e;

    function automatic logic [DATA_W-1:0] sext_lit(input logic [LIT_W-1:0] f);
        return {{(DATA_W-LIT_W){f[LIT_W-1]}}, f};
    endfunction

    function automatic logic known_mode(input logic [MODE_W-1:0] m);
        return m <= MODE_W'(AM_MIND);
    endfunction

endpackage

// File: rtl/of_addr_gen.sv
module of_addr_gen
    import opfetch_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] base,
    input  logic [LIT_W-1:0]  lit,
    output fetch_plan_t       plan
);
    logic [DATA_W-1:0] lit_x;

    assign lit_x = sext_lit(lit);

    always_comb begin
        plan        = '0;
        plan.nreads = RD_NONE;
        if (!known_mode(mode)) begin
            plan.bad = 1'b1;
        end else begin
            unique case (amode_e'(mode))
                AM_REG: begin
                    plan.value = base;
                end
                AM_IMM: begin
                    plan.value = lit_x;
                end
                AM_DISP: begin
                    plan.nreads = RD_ONE;
                    plan.addr   = base + lit_x;
                end
                AM_RIND: begin
                    plan.nreads = RD_ONE;
                    plan.addr   = base;
                end
                AM_DIRECT: begin
                    plan.nreads = RD_ONE;
                    plan.addr   = lit_x;
                end
                AM_MIND: begin
                    plan.nreads = RD_TWO;
                    plan.addr   = base;
                end
                default: plan.bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/of_mem_port.sv
module of_mem_port
    import opfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [DATA_W-1:0] launch_addr,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    port_state_e       st;
    logic [DATA_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= MP_IDLE;
            addr_q <= '0;
        end else begin
            unique case (st)
                MP_IDLE: begin
                    if (launch) begin
                        st     <= MP_REQ;
                        addr_q <= launch_addr;
                    end
                end
                MP_REQ: begin
                    if (mem_ready) st <= MP_WAIT;
                end
                MP_WAIT: begin
                    if (mem_rvalid) begin
                        if (launch) begin
                            st     <= MP_REQ;
                            addr_q <= launch_addr;
                        end else begin
                            st <= MP_IDLE;
                        end
                    end
                end
                default: st <= MP_IDLE;
            endcase
        end
    end

    assign mem_req   = (st == MP_REQ);
    assign mem_addr  = addr_q;
    assign rsp_valid = (st == MP_WAIT) && mem_rvalid;
    assign rsp_data  = mem_rdata;
endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
    import opfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [RIDX_W-1:0] rb_idx,
    input  logic [LIT_W-1:0]  lit,
    output logic              busy,
    output logic [RIDX_W-1:0] rf_a_idx,
    input  logic [DATA_W-1:0] rf_a_data,
    output logic [RIDX_W-1:0] rf_b_idx,
    input  logic [DATA_W-1:0] rf_b_data,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);
    top_state_e        st;
    logic [MODE_W-1:0] mode_q;
    logic [RIDX_W-1:0] ra_q;
    logic [RIDX_W-1:0] rb_q;
    logic [LIT_W-1:0]  lit_q;
    logic [DATA_W-1:0] opa_q;
    logic              two_q;
    logic              err_q;
    logic [DATA_W-1:0] operand_q;
    logic [DATA_W-1:0] result_q;

    fetch_plan_t       plan;
    logic              launch;
    logic [DATA_W-1:0] launch_addr;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;

    of_addr_gen u_agen (
        .mode (mode_q),
        .base (rf_b_data),
        .lit  (lit_q),
        .plan (plan)
    );

    of_mem_port u_port (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_addr (launch_addr),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ready   (mem_ready),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    always_comb begin
        launch      = 1'b0;
        launch_addr = plan.addr;
        if (st == TS_FETCH && !plan.bad && plan.nreads != RD_NONE) begin
            launch = 1'b1;
        end else if (st == TS_MEM1 && rsp_valid && two_q) begin
            launch      = 1'b1;
            launch_addr = rsp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= TS_IDLE;
            mode_q    <= '0;
            ra_q      <= '0;
            rb_q      <= '0;
            lit_q     <= '0;
            opa_q     <= '0;
            two_q     <= 1'b0;
            err_q     <= 1'b0;
            operand_q <= '0;
            result_q  <= '0;
        end else begin
            unique case (st)
                TS_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        ra_q   <= ra_idx;
                        rb_q   <= rb_idx;
                        lit_q  <= lit;
                        err_q  <= 1'b0;
                        st     <= TS_FETCH;
                    end
                end
                TS_FETCH: begin
                    opa_q <= rf_a_data;
                    two_q <= (plan.nreads == RD_TWO);
                    if (plan.bad) begin
                        err_q     <= 1'b1;
                        operand_q <= '0;
                        result_q  <= '0;
                        st        <= TS_DONE;
                    end else if (plan.nreads == RD_NONE) begin
                        operand_q <= plan.value;
                        result_q  <= rf_a_data + plan.value;
                        st        <= TS_DONE;
                    end else begin
                        st <= TS_MEM1;
                    end
                end
                TS_MEM1: begin
                    if (rsp_valid) begin
                        if (two_q) begin
                            st <= TS_MEM2;
                        end else begin
                            operand_q <= rsp_data;
                            result_q  <= opa_q + rsp_data;
                            st        <= TS_DONE;
                        end
                    end
                end
                TS_MEM2: begin
                    if (rsp_valid) begin
                        operand_q <= rsp_data;
                        result_q  <= opa_q + rsp_data;
                        st        <= TS_DONE;
                    end
                end
                TS_DONE: st <= TS_IDLE;
                default: st <= TS_IDLE;
            endcase
        end
    end

    assign busy     = (st != TS_IDLE);
    assign done     = (st == TS_DONE);
    assign err      = done && err_q;
    assign operand  = operand_q;
    assign result   = result_q;
    assign rf_a_idx = ra_q;
    assign rf_b_idx = rb_q;
endmodule

// File: rtl/of_checker.sv
module of_checker
    import opfetch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_addr
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

    // R8
    req_release_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready |=> !mem_req);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_frees_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !done);
endmodule

bind opnd_fetch_unit of_checker u_of_checker (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr)
);

// File: tb/opnd_fetch_unit_test.sv
module opnd_fetch_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [4:0]  ra_i = '0;
    logic [4:0]  rb_i = '0;
    logic [15:0] lit_i = '0;
    logic        busy;
    logic [4:0]  rf_a_idx, rf_b_idx;
    logic [31:0] rf_a_data, rf_b_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, err;
    logic [31:0] operand, result;

    always #2 clk = ~clk;

    function automatic logic [31:0] rff(input logic [4:0] i);
        return 32'h0000_1000 + {27'd0, i} * 32'h0137_0104;
    endfunction

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h3C3C_5A5A;
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] f);
        return {{16{f[15]}}, f};
    endfunction

    assign rf_a_data = rff(rf_a_idx);
    assign rf_b_data = rff(rf_b_idx);

    opnd_fetch_unit uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode_i),
        .ra_idx(ra_i), .rb_idx(rb_i), .lit(lit_i), .busy(busy),
        .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data),
        .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .err(err), .operand(operand), .result(result)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model, acting on the falling edge
    int          rdly_cfg = 0;
    int          sdly_cfg = 0;
    int          acc_n = 0;
    logic [31:0] acc_addr [0:63];
    int          hold_viol = 0;
    int          spur_req = 0;
    int          spur_done = 0;
    int          wcnt = 0;
    int          scnt = 0;
    bit          pend = 0;
    logic [31:0] pend_addr = '0;
    bit          prev_wait = 0;
    logic [31:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 0; mem_rvalid = 0; pend = 0; wcnt = 0; prev_wait = 0;
        end else begin
            if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_viol++;
            mem_ready  = 0;
            mem_rvalid = 0;
            if (pend) begin
                if (scnt >= sdly_cfg) begin
                    mem_rvalid = 1;
                    mem_rdata  = memf(pend_addr);
                    pend = 0;
                end else begin
                    scnt++;
                end
            end else if (mem_req) begin
                if (wcnt >= rdly_cfg) begin
                    mem_ready = 1;
                    acc_addr[acc_n % 64] = mem_addr;
                    acc_n++;
                    pend = 1; pend_addr = mem_addr; scnt = 0; wcnt = 0;
                end else begin
                    wcnt++;
                end
            end else if (spur_req != spur_done) begin
                mem_rvalid = 1;
                mem_rdata  = 32'hDEAD_0001;
                spur_done++;
            end
            prev_wait = mem_req && !mem_ready;
            prev_addr = mem_addr;
        end
    end

    typedef struct packed {
        logic [2:0]  mode;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [15:0] lit;
        logic [1:0]  rdly;
        logic [1:0]  sdly;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{3'd0, 5'd3,  5'd9,  16'h1234, 2'd0, 2'd0},
        '{3'd1, 5'd2,  5'd0,  16'h7FFF, 2'd0, 2'd0},
        '{3'd1, 5'd4,  5'd1,  16'h8001, 2'd0, 2'd0},
        '{3'd2, 5'd5,  5'd6,  16'h0040, 2'd0, 2'd0},
        '{3'd2, 5'd1,  5'd7,  16'hFFF0, 2'd2, 2'd1},
        '{3'd3, 5'd8,  5'd10, 16'h0000, 2'd1, 2'd2},
        '{3'd4, 5'd11, 5'd0,  16'h1200, 2'd0, 2'd3},
        '{3'd4, 5'd30, 5'd2,  16'h9000, 2'd3, 2'd0},
        '{3'd5, 5'd12, 5'd13, 16'h0000, 2'd0, 2'd0},
        '{3'd5, 5'd14, 5'd31, 16'h0007, 2'd3, 2'd3},
        '{3'd6, 5'd1,  5'd2,  16'h0004, 2'd0, 2'd0},
        '{3'd7, 5'd3,  5'd4,  16'h0008, 2'd1, 2'd1}
    };

    function automatic string reqname(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic run_op(input vec_t v, input bit poke_busy);
        logic [31:0] e_op, e_res, a1, a2;
        int          e_n, base_n, extra, waitc;
        bit          got;
        string       rq;
        rq = reqname(v.mode);
        a1 = 0; a2 = 0; e_n = 0; e_op = 0;
        case (v.mode)
            3'd0: e_op = rff(v.rb);
            3'd1: e_op = sx(v.lit);
            3'd2: begin e_n = 1; a1 = rff(v.rb) + sx(v.lit); e_op = memf(a1); end
            3'd3: begin e_n = 1; a1 = rff(v.rb); e_op = memf(a1); end
            3'd4: begin e_n = 1; a1 = sx(v.lit); e_op = memf(a1); end
            3'd5: begin e_n = 2; a1 = rff(v.rb); a2 = memf(a1); e_op = memf(a2); end
            default: e_op = 0;
        endcase
        e_res = (v.mode > 3'd5) ? 32'd0 : rff(v.ra) + e_op;
        rdly_cfg = int'(v.rdly);
        sdly_cfg = int'(v.sdly);
        base_n = acc_n;
        @(negedge clk);
        mode_i = v.mode; ra_i = v.ra; rb_i = v.rb; lit_i = v.lit; start = 1;
        @(negedge clk);
        start = 0;
        if (poke_busy) begin
            // R10: second start while busy
            mode_i = 3'd1; ra_i = 5'd0; lit_i = 16'h0101; start = 1;
            @(negedge clk);
            start = 0;
        end
        got = 0; waitc = 0;
        while (!got && waitc < 100) begin
            if (done) got = 1;
            else begin @(negedge clk); waitc++; end
        end
        chk(got, {rq, "/R9 done seen"}, 32'(got), 32'd1);
        chk(busy == 1'b1, "R9 busy during done", 32'(busy), 32'd1);
        chk(result == e_res, {rq, " result"}, result, e_res);
        chk(operand == e_op, {rq, " operand"}, operand, e_op);
        chk(err == (v.mode > 3'd5), {rq, " err"}, 32'(err), 32'(v.mode > 3'd5));
        extra = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) extra++;
            if (k == 0) chk(busy == 1'b0, "R9 busy after done", 32'(busy), 32'd0);
        end
        chk(extra == 0, poke_busy ? "R10 extra done" : "R9 extra done",
            32'(extra), 32'd0);
        chk(acc_n - base_n == e_n, {rq, " access count"}, 32'(acc_n - base_n), 32'(e_n));
        if (e_n >= 1) chk(acc_addr[base_n % 64] == a1, {rq, " first address"},
                          acc_addr[base_n % 64], a1);
        if (e_n == 2) chk(acc_addr[(base_n + 1) % 64] == a2, "R7 second address",
                          acc_addr[(base_n + 1) % 64], a2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(!done && !err, "R1 done/err after reset", {30'd0, done, err}, 32'd0);
        chk(!busy && !mem_req, "R1 busy/mem_req after reset", {30'd0, busy, mem_req}, 32'd0);

        for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);

        // R10: start while busy on a slow memory-indirect operation
        run_op('{3'd5, 5'd6, 5'd20, 16'h0000, 2'd2, 2'd1}, 1'b1);
        // R10: start while busy on a register operation
        run_op('{3'd0, 5'd17, 5'd18, 16'h0000, 2'd0, 2'd0}, 1'b1);

        // R8: stray response while idle must not complete or corrupt anything
        spur_req++;
        begin
            int seen = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (done) seen++;
            end
            chk(seen == 0, "R8 stray response gave done", 32'(seen), 32'd0);
        end
        run_op('{3'd3, 5'd9, 5'd21, 16'h0000, 2'd0, 2'd0}, 1'b0);

        chk(hold_viol == 0, "R8 request held until ready", 32'(hold_viol), 32'd0);
        finish_run();
    end
endmodule